// File: doc/BRIEF.md
# Modulo Timer with Overflow Interrupt

This block is a small memory-mapped timer built around an up-counter. Software picks a start value and a terminal value. It selects a clock, which starts the counter, and it chooses a power-of-two prescale ratio. The counter then climbs from the start value to the terminal value, drops back to the start value and repeats. Each time the counter drops back, a sticky overflow flag is set. When the overflow interrupt enable is also set, that flag drives the interrupt line.

A single-cycle register bus programs the block. A write is accepted on a rising clock edge when both select and write are high. Read data is a combinational function of the address. Software typically stops the timer, writes the terminal and start values, and writes the counter register to load the start value. It then starts the timer and, in its interrupt handler, clears the flag by writing zero to the flag bit.

Top module: `modtmr_top`

## Requirements
- R1: After reset all four registers read zero, `irq_o` is low and the counter does not move.
- R2: The counter advances only while the clock-select field (control bits 4:3) holds 1; with 0, 2 or 3 it holds its value.
- R3: With prescale value p in control bits 2:0, the counter takes one step every 2^p clock cycles, and the first step comes 2^p cycles after the select field becomes 1.
- R4: On a step where the count equals the modulo register, the counter loads the initial-count register. On any other step it increments, wrapping from 0xFFFF to 0. Started from value i with modulo m, the reload therefore happens on step ((m - i + 1) mod 2^16).
- R5: The overflow flag (control bit 7) is set by the same clock edge that performs the reload.
- R6: A control write with bit 7 at 0 clears the flag; a control write with bit 7 at 1 leaves the flag unchanged.
- R7: If a reload and a clearing control write happen on the same edge, the flag ends up set.
- R8: `irq_o` is high exactly while the flag and the interrupt enable (control bit 6) are both 1.
- R9: Any write to the counter register loads the initial-count value, whatever the write data, and it takes precedence over a step on the same edge.
- R10: The control register is at byte offset 0x00, the counter at 0x04, the modulo at 0x08 and the initial count at 0x4C. Counter, modulo and initial count keep the low 16 bits of write data. Control bit 5, every bit above the fields and every other address read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The counting path is exercised with a set of start/terminal/prescale triples, and the cycle count from start to the first interrupt is measured for each. Equal start and terminal values, a terminal of zero, a start above the terminal that forces a wrap through 0xFFFF, the largest terminal value and the largest prescale ratio each give a different count. An off-by-one in the reload compare, the divider phase or the wrap would therefore show up as a wrong cycle number rather than only as a wrong value. Directed cases then separate the non-running select codes from the running one. They also separate a clearing write from a set-preserving write, and they land a clearing write on a reload edge to check that the set wins.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
   // byte offsets of the registers
   localparam int unsigned OFS_CTRL = 32'h00;
   localparam int unsigned OFS_CNT  = 32'h04;
   localparam int unsigned OFS_MOD  = 32'h08;
   localparam int unsigned OFS_INIT = 32'h4C;

   // control register field positions
   localparam int unsigned CTRL_PS_LSB   = 0;
   localparam int unsigned CTRL_CS_LSB   = 3;
   localparam int unsigned CTRL_IE_BIT   = 6;
   localparam int unsigned CTRL_FLAG_BIT = 7;

   // clock-select code that runs the counter
   localparam int unsigned CS_RUN = 1;
endpackage

// File: rtl/modtmr_prescale.sv
module modtmr_prescale #(
   parameter int unsigned PS_W         = 3,
   parameter bit          HAS_PRESCALE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int unsigned DIV_W = (1 << PS_W) - 1;

   generate
      if (HAS_PRESCALE) begin : g_div
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] mask;

         // 2^ps - 1; a shift out of the top gives all ones
         assign mask = (DIV_W'(1) << ps) - DIV_W'(1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      div_q <= '0;
            else if (!run)   div_q <= '0;
            else             div_q <= div_q + DIV_W'(1);
         end

         assign tick = run && ((div_q & mask) == mask);
      end else begin : g_nodiv
         logic unused_ps;
         assign unused_ps = ^ps;
         assign tick      = run;
      end
   endgenerate
endmodule

// File: rtl/modtmr_core.sv
module modtmr_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] initv,
   input  logic [CNT_W-1:0] modv,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_mod;

   assign at_mod = (cnt_q == modv);
   assign hit    = tick && at_mod;
   assign cnt    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load)  cnt_q <= initv;
      else if (tick)  cnt_q <= at_mod ? initv : cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/modtmr_flag.sv
module modtmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;   // event beats software clear
      else if (clr)  flag <= 1'b0;
   end
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
   import modtmr_pkg::*;
#(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned PS_W         = 3,
   parameter int unsigned CS_W         = 2,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 32,
   parameter bit          HAS_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
   localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(OFS_MOD);
   localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(OFS_INIT);

   // elaboration-time parameter checks
   generate
      if (PS_W < 1 || PS_W > 3) begin : g_bad_ps
         $error("modtmr_top: PS_W must lie in 1..3");
      end
      if (CS_W != 2) begin : g_bad_cs
         $error("modtmr_top: CS_W must be 2");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("modtmr_top: CNT_W must lie in 2..DATA_W");
      end
      if (ADDR_W < 7 || DATA_W < 8) begin : g_bad_bus
         $error("modtmr_top: bus too narrow for the register map");
      end
   endgenerate

   logic [PS_W-1:0]  ps_q;
   logic [CS_W-1:0]  cs_q;
   logic             ie_q;
   logic             flag_q;
   logic [CNT_W-1:0] mod_q;
   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run, tick, hit;
   logic             wr_en, ctrl_wr, ctrl_clr, cnt_ld;

   assign wr_en    = bus_sel && bus_wr;
   assign ctrl_wr  = wr_en && (bus_addr == A_CTRL);
   assign cnt_ld   = wr_en && (bus_addr == A_CNT);
   assign ctrl_clr = ctrl_wr && !bus_wdata[CTRL_FLAG_BIT];
   assign run      = (cs_q == CS_W'(CS_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q   <= '0;
         cs_q   <= '0;
         ie_q   <= 1'b0;
         mod_q  <= '0;
         init_q <= '0;
      end else if (wr_en) begin
         if (bus_addr == A_CTRL) begin
            ps_q <= bus_wdata[CTRL_PS_LSB +: PS_W];
            cs_q <= bus_wdata[CTRL_CS_LSB +: CS_W];
            ie_q <= bus_wdata[CTRL_IE_BIT];
         end
         if (bus_addr == A_MOD)  mod_q  <= bus_wdata[CNT_W-1:0];
         if (bus_addr == A_INIT) init_q <= bus_wdata[CNT_W-1:0];
      end
   end

   generate
      if (CNT_W < DATA_W) begin : g_wd_unused
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];
      end
   endgenerate

   modtmr_prescale #(.PS_W(PS_W), .HAS_PRESCALE(HAS_PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .ps(ps_q), .tick(tick)
   );

   modtmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_ld),
      .initv(init_q), .modv(mod_q), .cnt(cnt_q), .hit(hit)
   );

   modtmr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(hit), .clr(ctrl_clr), .flag(flag_q)
   );

   assign irq_o = flag_q && ie_q;

   logic [DATA_W-1:0] ctrl_rd;
   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[CTRL_PS_LSB +: PS_W] = ps_q;
      ctrl_rd[CTRL_CS_LSB +: CS_W] = cs_q;
      ctrl_rd[CTRL_IE_BIT]         = ie_q;
      ctrl_rd[CTRL_FLAG_BIT]       = flag_q;
   end

   always_comb begin
      if (bus_addr == A_CTRL)      bus_rdata = ctrl_rd;
      else if (bus_addr == A_CNT)  bus_rdata = DATA_W'(cnt_q);
      else if (bus_addr == A_MOD)  bus_rdata = DATA_W'(mod_q);
      else if (bus_addr == A_INIT) bus_rdata = DATA_W'(init_q);
      else                         bus_rdata = '0;
   end
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             hit,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] modv,
   input logic [CNT_W-1:0] initv,
   input logic             cnt_ld,
   input logic             flag,
   input logic             ie,
   input logic             irq,
   input logic             ctrl_wr,
   input logic             ctrl_clr
);
   p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_ld) |=> $stable(cnt));

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_ld && cnt == modv) |=> (cnt == $past(initv)));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_ld && cnt != modv) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   p_flag_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(hit));

   p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && ctrl_wr && !ctrl_clr) |=> flag);

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctrl_clr) |=> flag);

   p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ie));

   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld |=> (cnt == $past(initv)));
endmodule

bind modtmr_top modtmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .hit(hit),
   .cnt(cnt_q), .modv(mod_q), .initv(init_q), .cnt_ld(cnt_ld),
   .flag(flag_q), .ie(ie_q), .irq(irq_o), .ctrl_wr(ctrl_wr),
   .ctrl_clr(ctrl_clr)
);

// File: tb/modtmr_top_tb.sv
`timescale 1ns/1ps
module modtmr_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          done = 1'b0;

   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_CNT  = 8'h04;
   localparam logic [7:0] A_MOD  = 8'h08;
   localparam logic [7:0] A_INIT = 8'h4C;

   always #4 clk = ~clk;   // 125 MHz

   modtmr_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   // {prescale[2:0], init[15:0], modulo[15:0]}
   localparam int NVEC = 8;
   localparam logic [34:0] VECS [NVEC] = '{
      {3'd0, 16'h0000, 16'h0005},
      {3'd1, 16'h0003, 16'h0007},
      {3'd3, 16'h0010, 16'h0012},
      {3'd0, 16'hFFF0, 16'hFFFF},
      {3'd2, 16'h0000, 16'h0000},
      {3'd7, 16'h0000, 16'h0001},
      {3'd0, 16'h0064, 16'h0064},
      {3'd0, 16'hFFFE, 16'h0002}
   };

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // starts and ends at a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      #1200000;
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: run did not finish");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
      rd(A_CNT,  v); check("R1 cnt",  v, 32'h0);
      rd(A_MOD,  v); check("R1 mod",  v, 32'h0);
      rd(A_INIT, v); check("R1 init", v, 32'h0);
      check("R1 irq", {31'h0, irq_o}, 32'h0);
      cycles(10);
      rd(A_CNT, v); check("R1 counter stopped", v, 32'h0);

      // R3 R4 R5 R8: vector table, cycles from start to first interrupt
      for (int i = 0; i < NVEC; i++) begin
         logic [2:0]  ps;
         logic [15:0] iv, mv, steps;
         int unsigned exp_n, n;
         {ps, iv, mv} = VECS[i];
         steps = mv - iv + 16'd1;
         exp_n = int'(steps) << ps;
         wr(A_CTRL, 32'h0);
         wr(A_MOD, {16'h0, mv});
         wr(A_INIT, {16'h0, iv});
         wr(A_CNT, 32'h0);
         wr(A_CTRL, 32'h48 | {29'h0, ps});
         n = 0;
         while (!irq_o && n < 4000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
         end
         check($sformatf("R3/R4 vec%0d cycles to overflow", i), n, exp_n);
         rd(A_CNT, v);
         check($sformatf("R4 vec%0d reloaded count", i), v, {16'h0, iv});
         rd(A_CTRL, v);
         check($sformatf("R5 vec%0d flag set", i), {31'h0, v[7]}, 32'h1);
      end

      // R2: only select code 1 runs the counter
      wr(A_CTRL, 32'h0);
      wr(A_MOD, 32'hFFFF);
      wr(A_INIT, 32'h0);
      wr(A_CNT, 32'h0);
      wr(A_CTRL, 32'h10);
      cycles(10);
      rd(A_CNT, v); check("R2 select 2 holds", v, 32'h0);
      wr(A_CTRL, 32'h18);
      cycles(10);
      rd(A_CNT, v); check("R2 select 3 holds", v, 32'h0);
      wr(A_CTRL, 32'h08);
      rd(A_CNT, v); check("R2 no step before first tick", v, 32'h0);
      cycles(5);
      rd(A_CNT, v); check("R2 select 1 runs", v, 32'h5);

      // R9: counter write loads initial count, beats a step
      wr(A_INIT, 32'h20);
      wr(A_CNT, 32'hABCD);
      rd(A_CNT, v); check("R9 write loads init", v, 32'h20);
      cycles(1);
      rd(A_CNT, v); check("R4 increments after load", v, 32'h21);

      // R6 R7 R8: flag behaviour
      wr(A_CTRL, 32'h0);
      wr(A_MOD, 32'h0);
      wr(A_INIT, 32'h0);
      wr(A_CNT, 32'h0);
      wr(A_CTRL, 32'h08);
      cycles(2);
      rd(A_CTRL, v); check("R5 flag with modulo 0", {31'h0, v[7]}, 32'h1);
      check("R8 irq low while enable 0", {31'h0, irq_o}, 32'h0);
      wr(A_CTRL, 32'h08);
      rd(A_CTRL, v); check("R7 set beats clear", {31'h0, v[7]}, 32'h1);
      wr(A_CTRL, 32'h80);
      wr(A_CTRL, 32'hC0);
      rd(A_CTRL, v); check("R6 writing one keeps flag", {31'h0, v[7]}, 32'h1);
      check("R8 irq high with flag and enable", {31'h0, irq_o}, 32'h1);
      wr(A_CTRL, 32'h40);
      rd(A_CTRL, v); check("R6 writing zero clears flag", {31'h0, v[7]}, 32'h0);
      check("R8 irq low after clear", {31'h0, irq_o}, 32'h0);

      // R10: field widths and unmapped space
      wr(A_MOD, 32'hFFFF_FFFF);
      rd(A_MOD, v); check("R10 modulo width", v, 32'h0000_FFFF);
      wr(A_INIT, 32'h1234_5678);
      rd(A_INIT, v); check("R10 init width", v, 32'h0000_5678);
      wr(A_CTRL, 32'hFFFF_FF7F);
      rd(A_CTRL, v); check("R10 ctrl unused bits", v, 32'h0000_005F);
      rd(8'h0C, v); check("R10 unmapped 0x0C", v, 32'h0);
      rd(8'h50, v); check("R10 unmapped 0x50", v, 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule